// File: doc/BRIEF.md
# Multi-Stream Multiply-With-Carry Random Word Generator

This peripheral supplies pseudo-random 32-bit words to software through a small register bus. It holds sixteen independent generator streams. Each stream advances by a pair of multiply-with-carry recurrences, and the generator is not a shift-register sequence. Software picks a stream by writing a select register. It can then seed that stream or pull successive words from it. A pull advances only the stream that is being read, so programs that own different streams never affect each other's sequences. Writing the same seed again restarts the same sequence. Stream 0 is set aside for boot firmware and the operating system.

Each stream keeps two 32-bit state words, z and w. In each state word, bits [15:0] hold the lag value and bits [31:16] hold the carry. One step replaces z with 36969·z[15:0] + z[31:16] and replaces w with 18000·w[15:0] + w[31:16]. The visible word is (z << 16) + w, taken modulo 2^32.

The bus decodes four word addresses: 0 is the stream select, 1 is the seed, 2 is the data port, and 3 is unused. Read data is combinational from the address. The read strobe matters only at the data address, where it advances the stream.

Top module: `mwc_rng_top`

## Requirements
- R1: After reset the select register reads 0. Stream i holds z = 0x5A5A + i and w = 0xC3C3 − i, with both carries zero, so its first data word is ((0x5A5A+i) << 16) + (0xC3C3 − i).
- R2: At address 2, bus_rdata equals (z[15:0] << 16) + w mod 2^32 of the selected stream. While no strobe is given, the value stays the same from cycle to cycle.
- R3: A cycle with bus_rd high at address 2 returns the current word. On that clock edge it steps the selected stream once: z' = 36969·z[15:0] + z[31:16] and w' = 18000·w[15:0] + w[31:16].
- R4: Stepping or seeding one stream leaves the state of every other stream unchanged.
- R5: A write to address 1 loads the selected stream with z = {16'h0, wdata[31:16]} and w = {16'h0, wdata[15:0]}. Loading the same seed again reproduces the same word sequence.
- R6: During a seed write, a zero z half is replaced by 0x9E37 and a zero w half is replaced by 0x7F4A.
- R7: A write to address 0 sets the select register to wdata[3:0] from the next cycle on. Address 0 reads the select register back, zero-extended.
- R8: Writes to address 2 or 3 change nothing. Addresses 1 and 3 read as zero. A strobe at any address other than 2 does not step a stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 2 | Word address of the register being accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe. At address 2 it steps the selected stream |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |

## Verification
The bench builds the block with its default parameters: sixteen streams, multipliers 36969 and 18000, and the default reset bases and fill constants. With these values every stream can be reached through the 4-bit select field, including an over-wide select write whose upper bits must be dropped. The reset seeds of all sixteen streams are read out, and repeated steps are compared against a model that works on full 32-bit carries. A replay test captures five words from a seeded stream and compares them with the words after the same seed is loaded again. The zero-half fill paths are also driven.

// File: rtl/mwc_pkg.sv
package mwc_pkg;

  localparam int HW   = 16;
  localparam int WORD = 2 * HW;

  localparam logic [1:0] ADDR_SEL  = 2'd0;
  localparam logic [1:0] ADDR_SEED = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  typedef struct packed {
    logic [WORD-1:0] z;
    logic [WORD-1:0] w;
  } mwc_state_t;

  // one multiply-with-carry step of a single half
  function automatic logic [WORD-1:0] half_step(input logic [WORD-1:0] s,
                                                input logic [HW-1:0]   m);
    half_step = ({{HW{1'b0}}, m} * {{HW{1'b0}}, s[HW-1:0]})
              + {{HW{1'b0}}, s[WORD-1:HW]};
  endfunction

  // seed value for a half, zero replaced by a fill constant
  function automatic logic [WORD-1:0] seed_half(input logic [HW-1:0] v,
                                                input logic [HW-1:0] fill);
    seed_half = {{HW{1'b0}}, (v == '0) ? fill : v};
  endfunction

  function automatic logic [WORD-1:0] out_word(input mwc_state_t st);
    out_word = {st.z[HW-1:0], {HW{1'b0}}} + st.w;
  endfunction

endpackage

// File: rtl/mwc_reg_if.sv
module mwc_reg_if
  import mwc_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [WORD-1:0]  bus_wdata,
  output logic [SEL_W-1:0] sel_q,
  output logic             seed_we,
  output logic             adv
);

  logic [SEL_W-1:0] sel_d;
  logic             sel_en;

  always_comb begin
    sel_en  = bus_wr && (bus_addr == ADDR_SEL);
    sel_d   = bus_wdata[SEL_W-1:0];
    seed_we = bus_wr && (bus_addr == ADDR_SEED);
    adv     = bus_rd && (bus_addr == ADDR_DATA);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

endmodule

// File: rtl/mwc_step.sv
module mwc_step
  import mwc_pkg::*;
#(
  parameter logic [HW-1:0] MULT_Z = 16'd36969,
  parameter logic [HW-1:0] MULT_W = 16'd18000
) (
  input  mwc_state_t cur,
  output mwc_state_t nxt
);

  always_comb begin
    nxt.z = half_step(cur.z, MULT_Z);
    nxt.w = half_step(cur.w, MULT_W);
  end

endmodule

// File: rtl/mwc_state_bank.sv
module mwc_state_bank
  import mwc_pkg::*;
#(
  parameter int              NUM_STREAMS = 16,
  parameter int              SEL_W       = 4,
  parameter logic [HW-1:0]   RST_Z_BASE  = 16'h5A5A,
  parameter logic [HW-1:0]   RST_W_BASE  = 16'hC3C3,
  parameter logic [HW-1:0]   FILL_Z      = 16'h9E37,
  parameter logic [HW-1:0]   FILL_W      = 16'h7F4A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             seed_we,
  input  logic [WORD-1:0]  seed_word,
  input  logic             adv,
  input  mwc_state_t       step_state,
  output mwc_state_t       cur_state
);

  mwc_state_t st_arr [NUM_STREAMS];
  mwc_state_t seeded;

  always_comb begin
    seeded.z = seed_half(seed_word[WORD-1:HW], FILL_Z);
    seeded.w = seed_half(seed_word[HW-1:0], FILL_W);
  end

  for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_stream
    localparam logic [HW-1:0] RZ = RST_Z_BASE + HW'(i);
    localparam logic [HW-1:0] RW = RST_W_BASE - HW'(i);

    mwc_state_t q;
    mwc_state_t d;
    logic       en;
    logic       hit;

    always_comb begin
      hit = (sel == SEL_W'(i));
      en  = hit && (seed_we || adv);
      d   = seed_we ? seeded : step_state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q.z <= {{HW{1'b0}}, RZ};
        q.w <= {{HW{1'b0}}, RW};
      end else if (en) begin
        q <= d;
      end
    end

    assign st_arr[i] = q;
  end

  assign cur_state = st_arr[sel];

endmodule

// File: rtl/mwc_rng_top.sv
module mwc_rng_top
  import mwc_pkg::*;
#(
  parameter int            NUM_STREAMS = 16,
  parameter logic [HW-1:0] MULT_Z      = 16'd36969,
  parameter logic [HW-1:0] MULT_W      = 16'd18000,
  parameter logic [HW-1:0] RST_Z_BASE  = 16'h5A5A,
  parameter logic [HW-1:0] RST_W_BASE  = 16'hC3C3,
  parameter logic [HW-1:0] FILL_Z      = 16'h9E37,
  parameter logic [HW-1:0] FILL_W      = 16'h7F4A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);

  localparam int SEL_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [SEL_W-1:0] sel_q;
  logic             seed_we;
  logic             adv;
  mwc_state_t       cur_state;
  mwc_state_t       step_state;
  logic [WORD-1:0]  cur_out;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  mwc_reg_if #(.SEL_W(SEL_W)) reg_if_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .sel_q     (sel_q),
    .seed_we   (seed_we),
    .adv       (adv)
  );

  mwc_state_bank #(
    .NUM_STREAMS (NUM_STREAMS),
    .SEL_W       (SEL_W),
    .RST_Z_BASE  (RST_Z_BASE),
    .RST_W_BASE  (RST_W_BASE),
    .FILL_Z      (FILL_Z),
    .FILL_W      (FILL_W)
  ) bank_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .sel        (sel_q),
    .seed_we    (seed_we),
    .seed_word  (bus_wdata),
    .adv        (adv),
    .step_state (step_state),
    .cur_state  (cur_state)
  );

  mwc_step #(.MULT_Z(MULT_Z), .MULT_W(MULT_W)) step_i (
    .cur (cur_state),
    .nxt (step_state)
  );

  assign cur_out = out_word(cur_state);

  always_comb begin
    case (bus_addr)
      ADDR_SEL:  bus_rdata = {{(32-SEL_W){1'b0}}, sel_q};
      ADDR_DATA: bus_rdata = cur_out;
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/mwc_rng_chk.sv
module mwc_rng_chk
  import mwc_pkg::*;
#(
  parameter int            SEL_W  = 4,
  parameter logic [HW-1:0] FILL_Z = 16'h9E37,
  parameter logic [HW-1:0] FILL_W = 16'h7F4A
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic [SEL_W-1:0] sel_q,
  input logic [31:0]      cur_out
);

  // R7
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0) |=> (sel_q == $past(bus_wdata[SEL_W-1:0])));

  // R7
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 2'd0) |=> $stable(sel_q));

  // R8
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3 || bus_addr == 2'd1) |-> (bus_rdata == 32'h0));

  // R2
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd2 && $past(bus_addr) == 2'd2 && !$past(bus_wr) && !$past(bus_rd))
      |-> $stable(bus_rdata));

  // R5 R6
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1) |=>
      (cur_out[31:16] == (($past(bus_wdata[31:16]) == 16'h0) ? FILL_Z : $past(bus_wdata[31:16]))
       && cur_out[15:0] == (($past(bus_wdata[15:0]) == 16'h0) ? FILL_W : $past(bus_wdata[15:0]))));

endmodule

bind mwc_rng_top mwc_rng_chk #(
  .SEL_W  (SEL_W),
  .FILL_Z (FILL_Z),
  .FILL_W (FILL_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .sel_q     (sel_q),
  .cur_out   (cur_out)
);

// File: tb/mwc_rng_top_tb.sv
module mwc_rng_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  logic [31:0] mz [16];
  logic [31:0] mw [16];
  logic [3:0]  msel;
  logic [31:0] last_rd;

  always #2 clk = ~clk;

  mwc_rng_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  function automatic logic [31:0] m_step(input logic [31:0] s, input logic [31:0] m);
    return m * (s & 32'h0000FFFF) + (s >> 16);
  endfunction

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0:    return {28'h0, msel};
      2'd2:    return (mz[msel] << 16) + mw[msel];
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic op(input logic wr, input logic rd, input logic [1:0] a,
                    input logic [31:0] d, input logic chk, input string tag);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    #1;
    last_rd = bus_rdata;
    if (chk) check(bus_rdata, m_read(a), tag);
    @(posedge clk);
    if (wr && a == 2'd1) begin
      mz[msel] = {16'h0, (d[31:16] == 16'h0) ? 16'h9E37 : d[31:16]};
      mw[msel] = {16'h0, (d[15:0] == 16'h0) ? 16'h7F4A : d[15:0]};
    end else if (rd && a == 2'd2) begin
      mz[msel] = m_step(mz[msel], 32'd36969);
      mw[msel] = m_step(mw[msel], 32'd18000);
    end
    if (wr && a == 2'd0) msel = d[3:0];
  endtask

  function automatic string tag_name(input logic [3:0] n);
    case (n)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  // {wr, rd, chk, tag[3:0], addr[1:0], wdata[31:0]}
  localparam int NV = 20;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 4'd7, 2'd0, 32'h0000_0003},
    {1'b0, 1'b1, 1'b1, 4'd7, 2'd0, 32'h0},
    {1'b1, 1'b0, 1'b0, 4'd5, 2'd1, 32'h1234_5678},
    {1'b0, 1'b1, 1'b1, 4'd5, 2'd2, 32'h0},
    {1'b0, 1'b1, 1'b1, 4'd3, 2'd2, 32'h0},
    {1'b0, 1'b1, 1'b1, 4'd3, 2'd2, 32'h0},
    {1'b1, 1'b0, 1'b0, 4'd4, 2'd0, 32'h0000_0007},
    {1'b0, 1'b1, 1'b1, 4'd4, 2'd2, 32'h0},
    {1'b1, 1'b0, 1'b0, 4'd4, 2'd0, 32'h0000_0003},
    {1'b0, 1'b1, 1'b1, 4'd4, 2'd2, 32'h0},
    {1'b0, 1'b0, 1'b1, 4'd2, 2'd2, 32'h0},
    {1'b0, 1'b0, 1'b1, 4'd2, 2'd2, 32'h0},
    {1'b1, 1'b0, 1'b0, 4'd8, 2'd2, 32'hFFFF_FFFF},
    {1'b0, 1'b0, 1'b1, 4'd8, 2'd2, 32'h0},
    {1'b0, 1'b1, 1'b1, 4'd8, 2'd3, 32'h0},
    {1'b1, 1'b0, 1'b0, 4'd8, 2'd3, 32'hDEAD_BEEF},
    {1'b0, 1'b1, 1'b1, 4'd8, 2'd1, 32'h0},
    {1'b0, 1'b0, 1'b1, 4'd8, 2'd2, 32'h0},
    {1'b1, 1'b0, 1'b0, 4'd7, 2'd0, 32'h0000_00F5},
    {1'b0, 1'b1, 1'b1, 4'd7, 2'd0, 32'h0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] cap [5];
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    for (int i = 0; i < 16; i++) begin
      mz[i] = 32'h5A5A + i;
      mw[i] = 32'hC3C3 - i;
    end
    msel = 4'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: select and every stream's first word
    op(1'b0, 1'b0, 2'd0, 32'h0, 1'b1, "R1");
    for (int i = 0; i < 16; i++) begin
      op(1'b1, 1'b0, 2'd0, 32'(i), 1'b0, "R1");
      op(1'b0, 1'b1, 2'd2, 32'h0, 1'b1, "R1");
      check(last_rd, ((32'h5A5A + 32'(i)) << 16) + (32'hC3C3 - 32'(i)), "R1");
    end

    // table of vectors
    for (int v = 0; v < NV; v++) begin
      op(VEC[v][40], VEC[v][39], VEC[v][33:32], VEC[v][31:0], VEC[v][38],
         tag_name(VEC[v][37:34]));
    end

    // R3: many steps on one stream
    op(1'b1, 1'b0, 2'd0, 32'd11, 1'b0, "R3");
    for (int k = 0; k < 40; k++) op(1'b0, 1'b1, 2'd2, 32'h0, 1'b1, "R3");

    // R5: replay a seed against captured words
    op(1'b1, 1'b0, 2'd0, 32'd9, 1'b0, "R5");
    op(1'b1, 1'b0, 2'd1, 32'hBEEF_0123, 1'b0, "R5");
    for (int k = 0; k < 5; k++) begin
      op(1'b0, 1'b1, 2'd2, 32'h0, 1'b1, "R5");
      cap[k] = last_rd;
    end
    op(1'b1, 1'b0, 2'd1, 32'hBEEF_0123, 1'b0, "R5");
    for (int k = 0; k < 5; k++) begin
      op(1'b0, 1'b1, 2'd2, 32'h0, 1'b0, "R5");
      check(last_rd, cap[k], "R5");
    end

    // R4: stream 3 keeps its place after stream 9 activity
    op(1'b1, 1'b0, 2'd0, 32'd3, 1'b0, "R4");
    op(1'b0, 1'b1, 2'd2, 32'h0, 1'b1, "R4");

    // R6: zero halves are filled
    op(1'b1, 1'b0, 2'd0, 32'd5, 1'b0, "R6");
    op(1'b1, 1'b0, 2'd1, 32'h0000_0000, 1'b0, "R6");
    op(1'b0, 1'b0, 2'd2, 32'h0, 1'b0, "R6");
    check(last_rd, 32'h9E37_7F4A, "R6");
    op(1'b1, 1'b0, 2'd1, 32'h0000_ABCD, 1'b0, "R6");
    op(1'b0, 1'b0, 2'd2, 32'h0, 1'b0, "R6");
    check(last_rd, 32'h9E37_ABCD, "R6");
    op(1'b1, 1'b0, 2'd1, 32'h1234_0000, 1'b0, "R6");
    op(1'b0, 1'b1, 2'd2, 32'h0, 1'b0, "R6");
    check(last_rd, 32'h1234_7F4A, "R6");
    op(1'b0, 1'b1, 2'd2, 32'h0, 1'b1, "R6");

    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule